// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block computes the architectural state change a core makes when it takes an exception, and commits it in one step. Each cycle the pipeline may present a fault strobe with a fault index and the current values of the PC, the next PC, and the status, shadow-set control and cause registers. On the clock edge where the strobe is high, the block registers the new register values, a write enable for each register, and the PC to redirect to. Boot-type faults and unhandled faults take their own paths.

The strobe is a plain qualifier and there is no ready: every strobe is accepted on its edge, so the block never pushes back. One fault is taken per strobe. Choosing among simultaneous faults, flushing the pipeline and returning from the handler belong to other blocks. Outputs are valid for the cycle after the strobe edge. The enables and flags are one-cycle pulses. The data outputs hold their last committed value until a later fault writes them.

Top module: `exc_entry_ctrl`

## Requirements
- R1: All outputs reset to zero. On the edge where `fault_valid` is high, `commit_o` pulses for one cycle. While `fault_valid` is low, every enable, `redirect_en` and `unimpl_o` is 0 on the next cycle, and the data outputs keep their values.
- R2: The fault index encodes: 0 boot reset, 1 warm reset, 2 non-maskable interrupt, 3 interrupt, 4 syscall, 5 reserved instruction, 6 thread, 7 overflow, 8 trap, 9 breakpoint, 10 signal-processing unit disabled, 11 machine check, 12 coprocessor unusable, 13 address error, 14 translation invalid, 15 translation refill, 16 translation modified. Indices 4 to 16 redirect to the vector base plus 0x180. Index 3 redirects to the vector base plus 0.
- R3: The vector base is 0xBFC00200 when the status bit BEV (bit 22) is 1, and 0x80000000 when it is 0.
- R4: For indices 3 to 16, the written status equals the input status with EXL (bit 1) forced to 1, even when EXL was already 1. All other bits are unchanged.
- R5: For indices 3 to 16, the shadow-set control is written only when EXL and BEV are both 0. In that case, bits [9:6] take the old bits [3:0], bits [3:0] take the old bits [15:12], and the other bits are kept. Otherwise `srsctl_we` stays 0 and `srsctl_o` holds.
- R6: A fault is in a delay slot when cur_pc + 4 differs from next_pc. EPC is written with cur_pc in that case minus 4, and with cur_pc otherwise.
- R7: Cause bits [6:2] take the exception code and bit 31 takes the delay-slot flag. All other cause bits are kept. The codes are: interrupt 0, translation modified 1, syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, machine check 24, and 0 for every other index.
- R8: Index 0 redirects to 0xBFC00000 and writes only the status register, equal to the input with bit 29 (coprocessor 1 usable) set.
- R9: Indices 1 and 2 pulse `unimpl_o`. They write no register and make no redirect.
- R10: Indices 17 to 31 are treated like R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_valid | input | 1 | Fault strobe, taken on the clock edge |
| fault_id | input | 5 | Fault index |
| cur_pc | input | 32 | PC of the faulting instruction |
| next_pc | input | 32 | PC that would follow it |
| status_i | input | 32 | Current status register |
| srsctl_i | input | 32 | Current shadow-set control register |
| cause_i | input | 32 | Current cause register |
| commit_o | output | 1 | Pulse: a fault was taken |
| status_we | output | 1 | Pulse: write status |
| status_o | output | 32 | New status value |
| srsctl_we | output | 1 | Pulse: write shadow-set control |
| srsctl_o | output | 32 | New shadow-set control value |
| cause_we | output | 1 | Pulse: write cause |
| cause_o | output | 32 | New cause value |
| epc_we | output | 1 | Pulse: write EPC |
| epc_o | output | 32 | New EPC value |
| redirect_en | output | 1 | Pulse: fetch from redirect_pc |
| redirect_pc | output | 32 | Redirect target |
| unimpl_o | output | 1 | Pulse: unhandled fault |

## Verification
On every cycle, the assertions check the following:
- the hold behaviour while the strobe is low;
- EXL being forced on every ordinary entry;
- the delay-slot relation between BD and EPC;
- the shadow-set rotation when EXL and BEV are both clear;
- the boot redirect;
- the unhandled-fault pulse.

Only the bench scenarios show the per-fault exception codes, the vector offset and base chosen for each index and BEV value, and the preservation of the untouched register bits. The bench covers these with directed faults and a long random mix that is compared against a behavioural model.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int REG_W        = 32;
  localparam int FAULT_W      = 5;
  localparam int CODE_W       = 5;
  localparam int ST_EXL       = 1;
  localparam int ST_BEV       = 22;
  localparam int ST_CU1       = 29;
  localparam int SS_FLD_W     = 4;
  localparam int SS_CUR_LO    = 0;
  localparam int SS_PREV_LO   = 6;
  localparam int SS_EXC_LO    = 12;
  localparam int CA_CODE_LO   = 2;
  localparam int CA_BD        = 31;

  typedef enum logic [FAULT_W-1:0] {
    F_BOOT      = 5'd0,
    F_WARM      = 5'd1,
    F_NMI       = 5'd2,
    F_INTR      = 5'd3,
    F_SYSCALL   = 5'd4,
    F_RSVD      = 5'd5,
    F_THREAD    = 5'd6,
    F_OVF       = 5'd7,
    F_TRAP      = 5'd8,
    F_BRK       = 5'd9,
    F_SPU_OFF   = 5'd10,
    F_MCHK      = 5'd11,
    F_COP_UNUSE = 5'd12,
    F_ADDR_ERR  = 5'd13,
    F_XL_INV    = 5'd14,
    F_XL_REFILL = 5'd15,
    F_XL_MOD    = 5'd16
  } fault_e;

  typedef enum logic [1:0] {
    CLS_BOOT   = 2'd0,
    CLS_UNIMPL = 2'd1,
    CLS_GEN    = 2'd2
  } fault_cls_e;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [FAULT_W-1:0] fault_id,
  output fault_cls_e         cls,
  output logic [CODE_W-1:0]  code,
  output logic               zero_off
);
  always_comb begin
    cls      = CLS_GEN;
    code     = '0;
    zero_off = 1'b0;
    case (fault_id)
      F_BOOT:      cls = CLS_BOOT;
      F_WARM,
      F_NMI:       cls = CLS_UNIMPL;
      F_INTR:      zero_off = 1'b1;
      F_XL_MOD:    code = CODE_W'(1);
      F_SYSCALL:   code = CODE_W'(8);
      F_BRK:       code = CODE_W'(9);
      F_RSVD:      code = CODE_W'(10);
      F_COP_UNUSE: code = CODE_W'(11);
      F_OVF:       code = CODE_W'(12);
      F_TRAP:      code = CODE_W'(13);
      F_MCHK:      code = CODE_W'(24);
      F_THREAD, F_SPU_OFF, F_ADDR_ERR,
      F_XL_INV, F_XL_REFILL: code = '0;
      default:     cls = CLS_UNIMPL;
    endcase
  end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc #(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] next_pc,
  output logic              in_delay,
  output logic [ADDR_W-1:0] epc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  always_comb begin
    in_delay = (cur_pc + STEP) != next_pc;
    epc      = in_delay ? (cur_pc - STEP) : cur_pc;
  end
endmodule

// File: rtl/exc_state_update.sv
module exc_state_update
  import exc_entry_pkg::*;
(
  input  logic              boot,
  input  logic [REG_W-1:0]  status_i,
  input  logic [REG_W-1:0]  srsctl_i,
  input  logic [REG_W-1:0]  cause_i,
  input  logic [CODE_W-1:0] code,
  input  logic              in_delay,
  output logic [REG_W-1:0]  status_n,
  output logic              rotate,
  output logic [REG_W-1:0]  srsctl_n,
  output logic [REG_W-1:0]  cause_n
);
  always_comb begin
    status_n = status_i;
    if (boot) status_n[ST_CU1] = 1'b1;
    else      status_n[ST_EXL] = 1'b1;

    rotate   = !status_i[ST_EXL] && !status_i[ST_BEV];
    srsctl_n = srsctl_i;
    srsctl_n[SS_PREV_LO +: SS_FLD_W] = srsctl_i[SS_CUR_LO +: SS_FLD_W];
    srsctl_n[SS_CUR_LO  +: SS_FLD_W] = srsctl_i[SS_EXC_LO +: SS_FLD_W];

    cause_n = cause_i;
    cause_n[CA_CODE_LO +: CODE_W] = code;
    cause_n[CA_BD]                = in_delay;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BOOT_VEC  = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] BASE_BEV  = 32'hBFC0_0200,
  parameter logic [ADDR_W-1:0] BASE_NORM = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] GEN_OFF   = 32'h0000_0180
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fault_valid,
  input  logic [FAULT_W-1:0]    fault_id,
  input  logic [ADDR_W-1:0]     cur_pc,
  input  logic [ADDR_W-1:0]     next_pc,
  input  logic [REG_W-1:0]      status_i,
  input  logic [REG_W-1:0]      srsctl_i,
  input  logic [REG_W-1:0]      cause_i,
  output logic                  commit_o,
  output logic                  status_we,
  output logic [REG_W-1:0]      status_o,
  output logic                  srsctl_we,
  output logic [REG_W-1:0]      srsctl_o,
  output logic                  cause_we,
  output logic [REG_W-1:0]      cause_o,
  output logic                  epc_we,
  output logic [ADDR_W-1:0]     epc_o,
  output logic                  redirect_en,
  output logic [ADDR_W-1:0]     redirect_pc,
  output logic                  unimpl_o
);
  fault_cls_e          cls;
  logic [CODE_W-1:0]   code;
  logic                zero_off;
  logic                in_delay;
  logic [ADDR_W-1:0]   epc_n;
  logic [REG_W-1:0]    status_n, srsctl_n, cause_n;
  logic                rotate;
  logic [ADDR_W-1:0]   vec_n;
  logic                is_gen, is_boot;

  exc_classify u_cls (
    .fault_id (fault_id),
    .cls      (cls),
    .code     (code),
    .zero_off (zero_off)
  );

  exc_epc_calc #(.ADDR_W(ADDR_W), .INSN_BYTES(4)) u_epc (
    .cur_pc   (cur_pc),
    .next_pc  (next_pc),
    .in_delay (in_delay),
    .epc      (epc_n)
  );

  exc_state_update u_upd (
    .boot     (is_boot),
    .status_i (status_i),
    .srsctl_i (srsctl_i),
    .cause_i  (cause_i),
    .code     (code),
    .in_delay (in_delay),
    .status_n (status_n),
    .rotate   (rotate),
    .srsctl_n (srsctl_n),
    .cause_n  (cause_n)
  );

  always_comb begin
    is_gen  = (cls == CLS_GEN);
    is_boot = (cls == CLS_BOOT);
    if (is_boot)
      vec_n = BOOT_VEC;
    else
      vec_n = (status_i[ST_BEV] ? BASE_BEV : BASE_NORM) + (zero_off ? '0 : GEN_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_o    <= 1'b0;
      status_we   <= 1'b0;
      srsctl_we   <= 1'b0;
      cause_we    <= 1'b0;
      epc_we      <= 1'b0;
      redirect_en <= 1'b0;
      unimpl_o    <= 1'b0;
      status_o    <= '0;
      srsctl_o    <= '0;
      cause_o     <= '0;
      epc_o       <= '0;
      redirect_pc <= '0;
    end else begin
      commit_o    <= fault_valid;
      status_we   <= fault_valid && (is_gen || is_boot);
      srsctl_we   <= fault_valid && is_gen && rotate;
      cause_we    <= fault_valid && is_gen;
      epc_we      <= fault_valid && is_gen;
      redirect_en <= fault_valid && (is_gen || is_boot);
      unimpl_o    <= fault_valid && (cls == CLS_UNIMPL);
      if (fault_valid && (is_gen || is_boot)) begin
        status_o    <= status_n;
        redirect_pc <= vec_n;
      end
      if (fault_valid && is_gen) begin
        cause_o <= cause_n;
        epc_o   <= epc_n;
        if (rotate) srsctl_o <= srsctl_n;
      end
    end
  end
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] BOOT_VEC = 32'hBFC0_0000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fault_valid,
  input logic [FAULT_W-1:0] fault_id,
  input logic [ADDR_W-1:0]  cur_pc,
  input logic [ADDR_W-1:0]  next_pc,
  input logic [REG_W-1:0]   status_i,
  input logic [REG_W-1:0]   srsctl_i,
  input logic               commit_o,
  input logic               status_we,
  input logic [REG_W-1:0]   status_o,
  input logic               srsctl_we,
  input logic [REG_W-1:0]   srsctl_o,
  input logic               cause_we,
  input logic [REG_W-1:0]   cause_o,
  input logic               epc_we,
  input logic [ADDR_W-1:0]  epc_o,
  input logic               redirect_en,
  input logic [ADDR_W-1:0]  redirect_pc,
  input logic               unimpl_o
);
  logic gen_f, unimpl_f, slot_f;
  always_comb begin
    gen_f    = fault_valid && fault_id >= 5'd3 && fault_id <= 5'd16;
    unimpl_f = fault_valid && (fault_id == 5'd1 || fault_id == 5'd2 || fault_id > 5'd16);
    slot_f   = (cur_pc + ADDR_W'(4)) != next_pc;
  end

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |=> !commit_o && !status_we && !cause_we && !epc_we && !redirect_en
                     && $stable(status_o) && $stable(epc_o) && $stable(redirect_pc));

  p_exl_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gen_f |=> status_we && status_o[ST_EXL] && redirect_en);

  p_shadow_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gen_f && !status_i[ST_EXL] && !status_i[ST_BEV] |=>
      srsctl_we && srsctl_o[SS_PREV_LO +: SS_FLD_W] == $past(srsctl_i[SS_CUR_LO +: SS_FLD_W]));

  p_no_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gen_f && (status_i[ST_EXL] || status_i[ST_BEV]) |=> !srsctl_we && $stable(srsctl_o));

  p_slot_epc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gen_f && slot_f |=> cause_o[CA_BD] && epc_o == $past(cur_pc) - ADDR_W'(4));

  p_noslot_epc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gen_f && !slot_f |=> !cause_o[CA_BD] && epc_o == $past(cur_pc) && cause_we && epc_we);

  p_boot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && fault_id == 5'd0 |=>
      redirect_en && redirect_pc == BOOT_VEC && status_o[ST_CU1] && !cause_we && !epc_we);

  p_unimpl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_f |=> unimpl_o && !redirect_en && !status_we && !srsctl_we && !cause_we && !epc_we);
endmodule

bind exc_entry_ctrl exc_entry_checker #(.ADDR_W(ADDR_W), .BOOT_VEC(BOOT_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_id(fault_id),
  .cur_pc(cur_pc), .next_pc(next_pc), .status_i(status_i), .srsctl_i(srsctl_i),
  .commit_o(commit_o), .status_we(status_we), .status_o(status_o),
  .srsctl_we(srsctl_we), .srsctl_o(srsctl_o), .cause_we(cause_we), .cause_o(cause_o),
  .epc_we(epc_we), .epc_o(epc_o), .redirect_en(redirect_en), .redirect_pc(redirect_pc),
  .unimpl_o(unimpl_o)
);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        fault_valid = 0;
  logic [4:0]  fault_id = 0;
  logic [31:0] cur_pc = 0, next_pc = 0, status_i = 0, srsctl_i = 0, cause_i = 0;
  logic        commit_o, status_we, srsctl_we, cause_we, epc_we, redirect_en, unimpl_o;
  logic [31:0] status_o, srsctl_o, cause_o, epc_o, redirect_pc;

  always #2 clk = ~clk;

  exc_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_id(fault_id),
    .cur_pc(cur_pc), .next_pc(next_pc), .status_i(status_i), .srsctl_i(srsctl_i),
    .cause_i(cause_i), .commit_o(commit_o), .status_we(status_we), .status_o(status_o),
    .srsctl_we(srsctl_we), .srsctl_o(srsctl_o), .cause_we(cause_we), .cause_o(cause_o),
    .epc_we(epc_we), .epc_o(epc_o), .redirect_en(redirect_en), .redirect_pc(redirect_pc),
    .unimpl_o(unimpl_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // expected registered outputs
  logic [6:0]  e_flags = 0; // commit,swe,rwe,cwe,ewe,rde,unimpl
  logic [31:0] e_st = 0, e_ss = 0, e_ca = 0, e_epc = 0, e_rpc = 0;
  string t_ctl = "R1", t_st = "R1", t_ss = "R1", t_ca = "R1", t_epc = "R1", t_pc = "R1";

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int code_of(int id);
    case (id)
      3: return 0;  16: return 1;  4: return 8;  9: return 9;
      5: return 10; 12: return 11; 7: return 12; 8: return 13;
      11: return 24;
      default: return 0;
    endcase
  endfunction

  task automatic compare_all();
    check(t_ctl, "flags", {25'd0, commit_o, status_we, srsctl_we, cause_we, epc_we, redirect_en, unimpl_o},
          {25'd0, e_flags});
    check(t_st,  "status",   status_o,    e_st);
    check(t_ss,  "srsctl",   srsctl_o,    e_ss);
    check(t_ca,  "cause",    cause_o,     e_ca);
    check(t_epc, "epc",      epc_o,       e_epc);
    check(t_pc,  "redirect", redirect_pc, e_rpc);
  endtask

  // compare outputs of the previous edge, then drive and model the next edge
  task automatic step(bit fv, int id, logic [31:0] pc, logic [31:0] npc,
                      logic [31:0] st, logic [31:0] ss, logic [31:0] ca);
    @(negedge clk);
    compare_all();
    fault_valid = fv; fault_id = id[4:0]; cur_pc = pc; next_pc = npc;
    status_i = st; srsctl_i = ss; cause_i = ca;
    if (!fv) begin
      e_flags = 0;
      t_ctl = "R1"; t_st = "R1"; t_ss = "R1"; t_ca = "R1"; t_epc = "R1"; t_pc = "R1";
    end else if (id == 0) begin
      e_flags = 7'b1100010;
      e_st = st | 32'h2000_0000;
      e_rpc = 32'hBFC0_0000;
      t_ctl = "R8"; t_st = "R8"; t_ss = "R8"; t_ca = "R8"; t_epc = "R8"; t_pc = "R8";
    end else if (id == 1 || id == 2 || id > 16) begin
      e_flags = 7'b1000001;
      t_ctl = (id > 16) ? "R10" : "R9";
      t_st = t_ctl; t_ss = t_ctl; t_ca = t_ctl; t_epc = t_ctl; t_pc = t_ctl;
    end else begin
      bit exl, bev, slot, rot;
      exl = st[1]; bev = st[22];
      slot = (pc + 4) != npc;
      rot = !exl && !bev;
      e_flags = {1'b1, 1'b1, rot, 1'b1, 1'b1, 1'b1, 1'b0};
      e_st = st | 32'h2;
      if (rot) e_ss = (ss & ~32'h3CF) | ((ss & 32'hF) << 6) | ((ss >> 12) & 32'hF);
      e_ca = (ca & ~32'h8000_007C) | (32'(code_of(id)) << 2) | (slot ? 32'h8000_0000 : 0);
      e_epc = slot ? pc - 4 : pc;
      e_rpc = (bev ? 32'hBFC0_0200 : 32'h8000_0000) + ((id == 3) ? 0 : 32'h180);
      t_ctl = "R4"; t_st = "R4"; t_ss = "R5"; t_ca = "R7"; t_epc = "R6";
      t_pc = bev ? "R3" : "R2";
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all(); // reset state, R1
    rst_n = 1;
    // syscall, no delay slot, EXL/BEV clear: rotation (R5) and offset 0x180 (R2)
    step(1, 4, 32'h0040_0100, 32'h0040_0104, 32'h0000_0010, 32'h0000_A003, 32'h0000_0300);
    // breakpoint in delay slot (R6), cause bits kept (R7)
    step(1, 9, 32'h0040_2000, 32'h0040_3000, 32'h0000_0000, 32'h0000_5001, 32'h0000_FF00);
    // strobe low: outputs hold (R1)
    step(0, 4, 32'h1234_5678, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(0, 0, 0, 0, 0, 0, 0);
    // interrupt with BEV set (R3): no rotation, zero offset
    step(1, 3, 32'h8000_1000, 32'h8000_1004, 32'h0040_0000, 32'h0000_F00F, 32'h0);
    // EXL already set: still set, no rotation (R4, R5)
    step(1, 12, 32'h8000_2000, 32'h8000_2004, 32'h0000_0002, 32'h0000_7002, 32'h0);
    // translation modified code 1, machine check code 24 (R7)
    step(1, 16, 32'h10, 32'h14, 32'h0, 32'h0000_3000, 32'h8000_0000);
    step(1, 11, 32'h20, 32'h100, 32'h0, 32'h0000_3000, 32'h0);
    // boot (R8), warm reset and NMI (R9), out-of-range (R10)
    step(1, 0, 32'h40, 32'h44, 32'h0000_0002, 32'h0, 32'h0);
    step(1, 1, 32'h50, 32'h54, 32'h0, 32'h0000_1000, 32'h0);
    step(1, 2, 32'h60, 32'h64, 32'h0, 32'h0000_1000, 32'h0);
    step(1, 23, 32'h70, 32'h74, 32'h0, 32'h0000_1000, 32'h0);
    step(1, 31, 32'h70, 32'h74, 32'h0, 32'h0000_1000, 32'h0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] pc, npc;
      pc = $urandom & 32'hFFFF_FFFC;
      npc = ($urandom % 3 == 0) ? ($urandom & 32'hFFFF_FFFC) : pc + 4;
      step(($urandom % 4) != 0, $urandom % 20, pc, npc,
           $urandom, $urandom, $urandom);
    end
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule